// File: doc/BRIEF.md
# Two-page shared RAM with per-page fixed-priority arbitration

This block is an on-chip RAM split into two equal pages of 16 KB, each of which can be reached by three masters: a DMA-side system bus (`ib_*`), a CPU data bus (`mb_*`) and a CPU instruction-fetch bus (`fb_*`). The fetch bus only reads. Every page has its own read port and its own write port, and each port has its own arbiter. Accesses that land on different pages, or a read and a write on the same page, are therefore served in the same cycle. When two masters want the same port of the same page, fixed priority picks the winner. The losing master sees `ready` low and holds its request until it is served.

Two run-time control vectors gate each page. `page_en` switches a page on or off. `page_wen` allows or blocks writes to a page. An access that falls outside the 32 KB window, or on a page that is switched off, completes at once and has no effect. The handshake is single-cycle: `ready` rises in the cycle of the grant, and read data follows one cycle later.

Top module: `ram_page_hub`

## Requirements
- R1: Page 0 answers byte addresses 0xFFF80000 to 0xFFF83FFF and page 1 answers 0xFFF84000 to 0xFFF87FFF. Address bit 14 picks the page and bits 13:2 pick the 32-bit word inside it.
- R2: When several read requests target the same live page in one cycle, the read port serves the system bus before the data bus, and the data bus before the fetch bus. Every loser sees ready low in that cycle.
- R3: When the system bus and the data bus both write the same live page in one cycle, the system bus wins the write port and the data bus sees ready low. The fetch bus has no write path.
- R4: Requests to different live pages in one cycle are all granted in that cycle.
- R5: On one page, a read and a write from different masters are both granted in the same cycle. If both target the same word, the read returns the contents from before the write.
- R6: A master's ready is high in the cycle its request is granted. A granted write changes memory at the clock edge that ends that cycle. Read data appears on that master's rdata in the following cycle, and rdata is zero in every cycle that does not follow a granted read by that master.
- R7: Write strobe bit k (k = 0..3) enables data bits 8k+7:8k. Bytes whose strobe is clear keep their old value.
- R8: When page_en bit p is 0, any access to page p gets ready in its request cycle without arbitration. A read returns zero and a write leaves memory unchanged.
- R9: When page_en bit p is 1 and page_wen bit p is 0, writes to page p still arbitrate and complete, but memory is left unchanged. Reads are unaffected.
- R10: An access outside the window gets ready in its request cycle, returns zero data and writes nothing.
- R11: While a master has no request its ready is low. After reset, all rdata outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_en | input | NPAGES | Per-page on/off control |
| page_wen | input | NPAGES | Per-page write permission |
| ib_req | input | 1 | System bus request |
| ib_we | input | 1 | System bus write (1) or read (0) |
| ib_addr | input | 32 | System bus byte address |
| ib_wdata | input | 32 | System bus write data |
| ib_be | input | 4 | System bus byte strobes |
| ib_ready | output | 1 | System bus access granted or completed |
| ib_rdata | output | 32 | System bus read data, one cycle after ready |
| mb_req | input | 1 | Data bus request |
| mb_we | input | 1 | Data bus write (1) or read (0) |
| mb_addr | input | 32 | Data bus byte address |
| mb_wdata | input | 32 | Data bus write data |
| mb_be | input | 4 | Data bus byte strobes |
| mb_ready | output | 1 | Data bus access granted or completed |
| mb_rdata | output | 32 | Data bus read data, one cycle after ready |
| fb_req | input | 1 | Fetch bus read request |
| fb_addr | input | 32 | Fetch bus byte address |
| fb_ready | output | 1 | Fetch bus access granted or completed |
| fb_rdata | output | 32 | Fetch bus read data, one cycle after ready |

## Verification
Ready depends combinationally on the request, so it is due in the cycle of the request itself. A granted write is visible from the next cycle on, and read data arrives exactly one cycle after ready. The bench drives inputs on the falling edge and samples 4 ns later, before the next rising edge. At each sample it compares ready against the model's decision for the same cycle, and rdata against the value the model predicted in the previous cycle. The model applies its writes only after it has evaluated that cycle's reads, so same-word read-during-write and dropped writes line up with the design cycle for cycle.

// File: rtl/rph_pkg.sv
package rph_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int N_MST  = 3;
  localparam int N_WMST = 2;

  // Index order is also arbitration order: lower index wins.
  typedef enum logic [1:0] {
    MST_DMA   = 2'd0,
    MST_DATA  = 2'd1,
    MST_FETCH = 2'd2
  } mst_e;

  function automatic logic [ADDR_W-1:0] win_offset(input logic [ADDR_W-1:0] addr,
                                                   input logic [ADDR_W-1:0] base);
    return addr - base;
  endfunction

  function automatic logic in_span(input logic [ADDR_W-1:0] off,
                                   input logic [ADDR_W-1:0] span);
    return off < span;
  endfunction

  function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [BE_W-1:0]   lanes);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int b = 0; b < BE_W; b++)
      if (lanes[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/rph_decode.sv
module rph_decode import rph_pkg::*; #(
  parameter logic [ADDR_W-1:0] BASE       = 32'hFFF8_0000,
  parameter int                PAGE_BYTES = 16384,
  parameter int                NPAGES     = 2,
  localparam int PAGE_SH = $clog2(PAGE_BYTES),
  localparam int LANE_SH = $clog2(BE_W),
  localparam int WORD_W  = PAGE_SH - LANE_SH,
  localparam int PG_W    = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [NPAGES-1:0] page_oh,
  output logic [WORD_W-1:0] word
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NPAGES * PAGE_BYTES);

  logic [ADDR_W-1:0] off;
  logic [PG_W-1:0]   pidx;

  assign off  = win_offset(addr, BASE);
  assign hit  = in_span(off, SPAN);
  assign pidx = off[PAGE_SH +: PG_W];
  assign word = off[LANE_SH +: WORD_W];

  always_comb begin
    page_oh = '0;
    for (int p = 0; p < NPAGES; p++)
      page_oh[p] = hit && (pidx == PG_W'(p));
  end
endmodule

// File: rtl/rph_prio_arb.sv
module rph_prio_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic taken;

  always_comb begin
    gnt   = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rph_page.sv
module rph_page import rph_pkg::*; #(
  parameter int WORDS  = 4096,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_word] <= merge_bytes(mem[wr_word], wr_data, wr_be);
    if (rd_en) rd_data <= mem[rd_word];
  end
endmodule

// File: rtl/ram_page_hub.sv
module ram_page_hub import rph_pkg::*; #(
  parameter logic [ADDR_W-1:0] BASE       = 32'hFFF8_0000,
  parameter int                PAGE_BYTES = 16384,
  parameter int                NPAGES     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPAGES-1:0] page_en,
  input  logic [NPAGES-1:0] page_wen,
  input  logic              ib_req,
  input  logic              ib_we,
  input  logic [ADDR_W-1:0] ib_addr,
  input  logic [DATA_W-1:0] ib_wdata,
  input  logic [BE_W-1:0]   ib_be,
  output logic              ib_ready,
  output logic [DATA_W-1:0] ib_rdata,
  input  logic              mb_req,
  input  logic              mb_we,
  input  logic [ADDR_W-1:0] mb_addr,
  input  logic [DATA_W-1:0] mb_wdata,
  input  logic [BE_W-1:0]   mb_be,
  output logic              mb_ready,
  output logic [DATA_W-1:0] mb_rdata,
  input  logic              fb_req,
  input  logic [ADDR_W-1:0] fb_addr,
  output logic              fb_ready,
  output logic [DATA_W-1:0] fb_rdata
);
  localparam int PAGE_SH = $clog2(PAGE_BYTES);
  localparam int LANE_SH = $clog2(BE_W);
  localparam int WORD_W  = PAGE_SH - LANE_SH;
  localparam int WORDS   = 1 << WORD_W;

  // Master bundles, indexed by mst_e
  logic [N_MST-1:0]  m_req, m_we;
  logic [ADDR_W-1:0] m_addr [N_MST];
  logic [DATA_W-1:0] w_data [N_WMST];
  logic [BE_W-1:0]   w_be   [N_WMST];

  assign m_req = {fb_req, mb_req, ib_req};
  assign m_we  = {1'b0,   mb_we,  ib_we};
  assign m_addr[int'(MST_DMA)]   = ib_addr;
  assign m_addr[int'(MST_DATA)]  = mb_addr;
  assign m_addr[int'(MST_FETCH)] = fb_addr;
  assign w_data[int'(MST_DMA)]   = ib_wdata;
  assign w_data[int'(MST_DATA)]  = mb_wdata;
  assign w_be[int'(MST_DMA)]     = ib_be;
  assign w_be[int'(MST_DATA)]    = mb_be;

  // Named events for the checker
  logic [N_MST-1:0]        mst_hit_bus;
  logic [N_MST*NPAGES-1:0] mst_page_oh_bus;
  logic [NPAGES*N_MST-1:0] rd_gnt_bus;
  logic [NPAGES*N_WMST-1:0] wr_gnt_bus;
  logic [N_MST-1:0]        mst_live, mst_bypass, mst_gnt, mst_ready;

  logic [NPAGES-1:0] mst_oh   [N_MST];
  logic [WORD_W-1:0] mst_word [N_MST];
  logic [DATA_W-1:0] page_rdata [NPAGES];
  logic [NPAGES-1:0] rsrc [N_MST];
  logic [DATA_W-1:0] mst_rdata [N_MST];

  // Address decode, one per master
  for (genvar m = 0; m < N_MST; m++) begin : g_dec
    rph_decode #(.BASE(BASE), .PAGE_BYTES(PAGE_BYTES), .NPAGES(NPAGES)) u_dec (
      .addr    (m_addr[m]),
      .hit     (mst_hit_bus[m]),
      .page_oh (mst_oh[m]),
      .word    (mst_word[m])
    );
    assign mst_page_oh_bus[m*NPAGES +: NPAGES] = mst_oh[m];
  end

  // A request on a dead page or outside the window completes at once
  always_comb begin
    for (int m = 0; m < N_MST; m++) begin
      mst_live[m]   = |(mst_oh[m] & page_en);
      mst_bypass[m] = m_req[m] & ~mst_live[m];
    end
  end

  // One read port and one write port per page, each with its own arbiter
  for (genvar p = 0; p < NPAGES; p++) begin : g_page
    logic [N_MST-1:0]  rd_req, rd_gnt;
    logic [N_WMST-1:0] wr_req, wr_gnt;
    logic [WORD_W-1:0] rd_word, wr_word;
    logic [DATA_W-1:0] wr_data, rd_q;
    logic [BE_W-1:0]   wr_be;

    always_comb begin
      for (int m = 0; m < N_MST; m++)
        rd_req[m] = m_req[m] & ~m_we[m] & mst_oh[m][p] & page_en[p];
      for (int m = 0; m < N_WMST; m++)
        wr_req[m] = m_req[m] & m_we[m] & mst_oh[m][p] & page_en[p];
    end

    rph_prio_arb #(.N(N_MST))  u_rd_arb (.req(rd_req), .gnt(rd_gnt));
    rph_prio_arb #(.N(N_WMST)) u_wr_arb (.req(wr_req), .gnt(wr_gnt));

    always_comb begin
      rd_word = '0;
      wr_word = '0;
      wr_data = '0;
      wr_be   = '0;
      for (int m = 0; m < N_MST; m++)
        if (rd_gnt[m]) rd_word = mst_word[m];
      for (int m = 0; m < N_WMST; m++)
        if (wr_gnt[m]) begin
          wr_word = mst_word[m];
          wr_data = w_data[m];
          wr_be   = w_be[m];
        end
    end

    rph_page #(.WORDS(WORDS), .WORD_W(WORD_W)) u_mem (
      .clk     (clk),
      .rd_en   (|rd_gnt),
      .rd_word (rd_word),
      .rd_data (rd_q),
      .wr_en   ((|wr_gnt) & page_wen[p]),
      .wr_word (wr_word),
      .wr_data (wr_data),
      .wr_be   (wr_be)
    );

    assign rd_gnt_bus[p*N_MST  +: N_MST]  = rd_gnt;
    assign wr_gnt_bus[p*N_WMST +: N_WMST] = wr_gnt;
    assign page_rdata[p] = rd_q;
  end

  // Grants gathered per master
  always_comb begin
    mst_gnt = '0;
    for (int p = 0; p < NPAGES; p++) begin
      for (int m = 0; m < N_MST; m++)
        mst_gnt[m] = mst_gnt[m] | rd_gnt_bus[p*N_MST + m];
      for (int m = 0; m < N_WMST; m++)
        mst_gnt[m] = mst_gnt[m] | wr_gnt_bus[p*N_WMST + m];
    end
  end

  assign mst_ready = mst_bypass | mst_gnt;

  // Which page each master's read came from, for the return cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < N_MST; m++) rsrc[m] <= '0;
    end else begin
      for (int m = 0; m < N_MST; m++)
        for (int p = 0; p < NPAGES; p++)
          rsrc[m][p] <= rd_gnt_bus[p*N_MST + m];
    end
  end

  always_comb begin
    for (int m = 0; m < N_MST; m++) begin
      mst_rdata[m] = '0;
      for (int p = 0; p < NPAGES; p++)
        if (rsrc[m][p]) mst_rdata[m] = mst_rdata[m] | page_rdata[p];
    end
  end

  assign ib_ready = mst_ready[int'(MST_DMA)];
  assign mb_ready = mst_ready[int'(MST_DATA)];
  assign fb_ready = mst_ready[int'(MST_FETCH)];
  assign ib_rdata = mst_rdata[int'(MST_DMA)];
  assign mb_rdata = mst_rdata[int'(MST_DATA)];
  assign fb_rdata = mst_rdata[int'(MST_FETCH)];
endmodule

// File: rtl/rph_checker.sv
module rph_checker import rph_pkg::*; #(
  parameter int NPAGES = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPAGES-1:0]        page_en,
  input logic                     ib_req,
  input logic                     ib_we,
  input logic                     ib_ready,
  input logic [DATA_W-1:0]        ib_rdata,
  input logic                     mb_req,
  input logic                     mb_we,
  input logic                     mb_ready,
  input logic [DATA_W-1:0]        mb_rdata,
  input logic                     fb_req,
  input logic                     fb_ready,
  input logic [DATA_W-1:0]        fb_rdata,
  input logic [N_MST-1:0]         mst_hit_bus,
  input logic [N_MST*NPAGES-1:0]  mst_page_oh_bus,
  input logic [NPAGES*N_MST-1:0]  rd_gnt_bus,
  input logic [NPAGES*N_WMST-1:0] wr_gnt_bus
);
  logic [NPAGES-1:0] ib_oh, mb_oh, fb_oh;
  logic ib_live, mb_live, fb_live;
  logic ib_rd, mb_rd, fb_rd, ib_wr, mb_wr;

  assign ib_oh   = mst_page_oh_bus[0*NPAGES +: NPAGES];
  assign mb_oh   = mst_page_oh_bus[1*NPAGES +: NPAGES];
  assign fb_oh   = mst_page_oh_bus[2*NPAGES +: NPAGES];
  assign ib_live = |(ib_oh & page_en);
  assign mb_live = |(mb_oh & page_en);
  assign fb_live = |(fb_oh & page_en);
  assign ib_rd   = ib_req & !ib_we & ib_live;
  assign mb_rd   = mb_req & !mb_we & mb_live;
  assign fb_rd   = fb_req & fb_live;
  assign ib_wr   = ib_req & ib_we & ib_live;
  assign mb_wr   = mb_req & mb_we & mb_live;

  for (genvar p = 0; p < NPAGES; p++) begin : g_pg
    a_r2_read_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_gnt_bus[p*N_MST +: N_MST]));
    a_r3_write_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_gnt_bus[p*N_WMST +: N_WMST]));
  end

  a_r2_data_bus_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_rd && mb_rd && |(ib_oh & mb_oh)) |-> !mb_ready);

  a_r2_fetch_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rd && ((ib_rd && |(ib_oh & fb_oh)) || (mb_rd && |(mb_oh & fb_oh)))) |-> !fb_ready);

  a_r3_write_port_order: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_wr && mb_wr && |(ib_oh & mb_oh)) |-> (ib_ready && !mb_ready));

  a_r4_split_pages: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && ib_live && mb_req && mb_live && !(|(ib_oh & mb_oh))) |-> (ib_ready && mb_ready));

  a_r5_read_beside_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_wr && mb_rd && |(ib_oh & mb_oh)) |-> (ib_ready && mb_ready));

  a_r6_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_req && mb_ready && !mb_we) |=> (mb_rdata == '0));

  a_r8_dead_page_done: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_req && !fb_live) |-> fb_ready);

  a_r8_dead_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_req && !fb_live) |=> (fb_rdata == '0));

  a_r10_outside_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((ib_req && !mst_hit_bus[0]) || (mb_req && !mst_hit_bus[1]) || (fb_req && !mst_hit_bus[2]))
    |-> ((ib_ready || !ib_req || mst_hit_bus[0]) && (mb_ready || !mb_req || mst_hit_bus[1]) &&
         (fb_ready || !fb_req || mst_hit_bus[2])));

  a_r10_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && !ib_we && !mst_hit_bus[0]) |=> (ib_rdata == '0));

  a_r11_no_req_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!ib_req || ib_ready) && (!mb_req || mb_ready || 1'b1) |-> ((ib_req || !ib_ready) && (mb_req || !mb_ready) && (fb_req || !fb_ready)));
endmodule

bind ram_page_hub rph_checker #(.NPAGES(NPAGES)) u_rph_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .page_en         (page_en),
  .ib_req          (ib_req),
  .ib_we           (ib_we),
  .ib_ready        (ib_ready),
  .ib_rdata        (ib_rdata),
  .mb_req          (mb_req),
  .mb_we           (mb_we),
  .mb_ready        (mb_ready),
  .mb_rdata        (mb_rdata),
  .fb_req          (fb_req),
  .fb_ready        (fb_ready),
  .fb_rdata        (fb_rdata),
  .mst_hit_bus     (mst_hit_bus),
  .mst_page_oh_bus (mst_page_oh_bus),
  .rd_gnt_bus      (rd_gnt_bus),
  .wr_gnt_bus      (wr_gnt_bus)
);

// File: tb/ram_page_hub_test.sv
module ram_page_hub_test;
  localparam int          NPG  = 2;
  localparam int          PB   = 16384;
  localparam logic [31:0] BASE = 32'hFFF8_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NPG-1:0] page_en, page_wen;
  logic ib_req, ib_we, mb_req, mb_we, fb_req;
  logic [31:0] ib_addr, ib_wdata, mb_addr, mb_wdata, fb_addr;
  logic [3:0]  ib_be, mb_be;
  logic ib_ready, mb_ready, fb_ready;
  logic [31:0] ib_rdata, mb_rdata, fb_rdata;

  ram_page_hub uut (
    .clk(clk), .rst_n(rst_n), .page_en(page_en), .page_wen(page_wen),
    .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata), .ib_be(ib_be),
    .ib_ready(ib_ready), .ib_rdata(ib_rdata),
    .mb_req(mb_req), .mb_we(mb_we), .mb_addr(mb_addr), .mb_wdata(mb_wdata), .mb_be(mb_be),
    .mb_ready(mb_ready), .mb_rdata(mb_rdata),
    .fb_req(fb_req), .fb_addr(fb_addr), .fb_ready(fb_ready), .fb_rdata(fb_rdata)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R11";
  bit [31:0] mdl [int];
  bit [31:0] exp_rd [3];

  function automatic logic [31:0] A(int pg, int wd);
    return BASE + 32'(pg * PB) + 32'(wd * 4);
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drv_ib(bit r, bit w, logic [31:0] a, logic [31:0] d = 0, logic [3:0] b = 4'hF);
    ib_req = r; ib_we = w; ib_addr = a; ib_wdata = d; ib_be = b;
  endtask
  task automatic drv_mb(bit r, bit w, logic [31:0] a, logic [31:0] d = 0, logic [3:0] b = 4'hF);
    mb_req = r; mb_we = w; mb_addr = a; mb_wdata = d; mb_be = b;
  endtask
  task automatic drv_fb(bit r, logic [31:0] a);
    fb_req = r; fb_addr = a;
  endtask
  task automatic idle();
    drv_ib(0, 0, 0); drv_mb(0, 0, 0); drv_fb(0, 0);
  endtask

  // One cycle: sample, compare with the model, advance the model, move to next falling edge
  task automatic step();
    bit        rq [3];
    bit        wq [3];
    logic [31:0] ad [3];
    logic [31:0] wd [3];
    logic [3:0]  bs [3];
    bit        inw [3];
    int        pgm [3];
    int        wdx [3];
    bit        got [3];
    bit [31:0] nxt [3];
    int        wwin [NPG];
    longint    off;
    bit        rtaken, wtaken;
    bit [31:0] cur;
    int        key;
    #4;
    rq[0] = ib_req; rq[1] = mb_req; rq[2] = fb_req;
    wq[0] = ib_we;  wq[1] = mb_we;  wq[2] = 1'b0;
    ad[0] = ib_addr; ad[1] = mb_addr; ad[2] = fb_addr;
    wd[0] = ib_wdata; wd[1] = mb_wdata; wd[2] = 0;
    bs[0] = ib_be; bs[1] = mb_be; bs[2] = 0;
    for (int m = 0; m < 3; m++) begin
      off    = longint'(ad[m]) - longint'(BASE);
      inw[m] = (off >= 0) && (off < NPG * PB);
      pgm[m] = inw[m] ? int'(off / PB) : 0;
      wdx[m] = inw[m] ? int'((off % PB) / 4) : 0;
      got[m] = 1'b0;
      nxt[m] = 0;
    end
    for (int pg = 0; pg < NPG; pg++) begin
      rtaken = 0; wtaken = 0; wwin[pg] = -1;
      for (int m = 0; m < 3; m++) begin
        if (rq[m] && inw[m] && pgm[m] == pg && page_en[pg]) begin
          if (wq[m]) begin
            if (!wtaken) begin wtaken = 1; got[m] = 1; wwin[pg] = m; end
          end else if (!rtaken) begin
            rtaken = 1; got[m] = 1;
            key = pg * 4096 + wdx[m];
            nxt[m] = mdl.exists(key) ? mdl[key] : 32'h0;
          end
        end
      end
    end
    for (int m = 0; m < 3; m++) begin
      chk($sformatf("ready[%0d]", m),
          {31'b0, (m == 0) ? ib_ready : (m == 1) ? mb_ready : fb_ready},
          {31'b0, rq[m] && (!inw[m] || !page_en[pgm[m]] || got[m])});
      chk($sformatf("rdata[%0d]", m),
          (m == 0) ? ib_rdata : (m == 1) ? mb_rdata : fb_rdata, exp_rd[m]);
      exp_rd[m] = nxt[m];
    end
    for (int pg = 0; pg < NPG; pg++) begin
      if (wwin[pg] >= 0 && page_wen[pg]) begin
        key = pg * 4096 + wdx[wwin[pg]];
        cur = mdl.exists(key) ? mdl[key] : 32'h0;
        for (int b = 0; b < 4; b++)
          if (bs[wwin[pg]][b]) cur[b*8 +: 8] = wd[wwin[pg]][b*8 +: 8];
        mdl[key] = cur;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    page_en = '1; page_wen = '1;
    idle();
    for (int m = 0; m < 3; m++) exp_rd[m] = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    tag = "R11";
    #4;
    chk("reset ready", {29'b0, ib_ready, mb_ready, fb_ready}, 32'h0);
    chk("reset rdata ib", ib_rdata, 32'h0);
    chk("reset rdata fb", fb_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step();

    // R4: preload both pages in parallel, one page per master
    tag = "R4";
    for (int w = 0; w < 8; w++) begin
      drv_ib(1, 1, A(0, w), 32'h1000_0000 + 32'(w));
      drv_mb(1, 1, A(1, w), 32'h2000_0000 + 32'(w));
      step();
    end
    // R1: decode of both pages, read back over two buses at once
    tag = "R1";
    idle();
    drv_ib(1, 0, A(0, 3)); drv_fb(1, A(1, 7));
    step();
    idle(); step();

    // R2: three readers on page 0, served one per cycle in priority order
    tag = "R2";
    drv_ib(1, 0, A(0, 1)); drv_mb(1, 0, A(0, 2)); drv_fb(1, A(0, 3));
    step();
    drv_ib(0, 0, 0); step();
    drv_mb(0, 0, 0); step();
    idle(); step();

    // R3: two writers on page 1
    tag = "R3";
    drv_ib(1, 1, A(1, 0), 32'hCAFE_0001); drv_mb(1, 1, A(1, 1), 32'hBEEF_0002);
    step();
    drv_ib(0, 0, 0); step();
    idle(); drv_ib(1, 0, A(1, 0)); drv_mb(1, 0, A(1, 1)); step();
    idle(); step();

    // R5: write and read of the same word in one cycle
    tag = "R5";
    drv_ib(1, 1, A(0, 4), 32'h5555_AAAA); drv_mb(1, 0, A(0, 4));
    step();
    idle(); drv_mb(1, 0, A(0, 4)); step();
    idle(); step();

    // R7: byte strobes
    tag = "R7";
    drv_mb(1, 1, A(0, 5), 32'hAABB_CCDD, 4'b0101); step();
    idle(); drv_fb(1, A(0, 5)); step();
    idle(); step();

    // R8: page 1 switched off
    tag = "R8";
    page_en = 2'b01;
    drv_mb(1, 0, A(1, 2)); drv_ib(1, 1, A(1, 2), 32'hDEAD_DEAD); drv_fb(1, A(1, 3));
    step();
    idle(); step();
    page_en = 2'b11;
    drv_mb(1, 0, A(1, 2)); step();
    idle(); step();

    // R9: page 0 write-protected, arbitration still runs
    tag = "R9";
    page_wen = 2'b10;
    drv_ib(1, 1, A(0, 6), 32'h0BAD_0BAD); drv_mb(1, 1, A(0, 6), 32'h0BAD_0BAD); step();
    drv_ib(0, 0, 0); step();
    page_wen = 2'b11;
    idle(); drv_ib(1, 0, A(0, 6)); step();
    idle(); step();

    // R10: outside the window
    tag = "R10";
    drv_ib(1, 0, 32'h0000_1000); drv_fb(1, 32'hFFF8_8000); drv_mb(1, 1, 32'hFFF7_FFFC, 32'h1234_5678);
    step();
    idle(); step();

    // R6: mixed traffic against the model
    tag = "R6";
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(31) == 0) page_en  = 2'($urandom_range(3));
      if ($urandom_range(31) == 0) page_wen = 2'($urandom_range(3));
      if ($urandom_range(15) == 0) begin page_en = 2'b11; page_wen = 2'b11; end
      drv_ib($urandom_range(1), $urandom_range(1),
             ($urandom_range(15) == 0) ? 32'hFFF9_0000 : A($urandom_range(1), $urandom_range(7)),
             $urandom, 4'($urandom_range(15)));
      drv_mb($urandom_range(1), $urandom_range(1),
             ($urandom_range(15) == 0) ? 32'hFFF7_0000 : A($urandom_range(1), $urandom_range(7)),
             $urandom, 4'($urandom_range(15)));
      drv_fb($urandom_range(1), A($urandom_range(1), $urandom_range(7)));
      step();
    end
    idle(); step();

    if (!done) begin
      done = 1'b1;
      finish_up();
    end
  end
endmodule